// File: doc/BRIEF.md
# Shared Bus Arbiter with DMA Atomicity and External Release

This block decides, bus cycle by bus cycle, which of three masters owns one shared bus: a DMA engine, a second on-chip transfer master and the CPU. Each master presents a request and a flag that tells whether the access targets external space. The DMA engine also reports its transfer kind (cycle-steal, burst or block), whether its current cycle is the read half of a read–write pair, and whether the bus is moving to a different DMA channel. A registered one-hot grant changes only when the bus reports the end of a cycle, or at once when the bus is idle.

A DMA read and its write always go out back to back, with nothing in between. In burst or block runs the DMA engine either keeps the bus outright or alternates with the on-chip masters, as an alternation enable selects. An external agent may ask for the external bus through a request and acknowledge pair. The acknowledge is given only on a cycle boundary that does not split a DMA pair. While it is held, no access to external space is granted, but internal-space traffic goes on.

Top module: `shared_bus_arb`

## Requirements
- R1: `gnt` is one-hot or zero, with bit 0 for the DMA engine, bit 1 for the transfer master and bit 2 for the CPU. It changes only on a clock edge where `cyc_done` is 1 or `gnt` is zero.
- R2: After a DMA cycle granted with `dma_rd`=1 ends, the next grant goes to the DMA engine for its write. `rel_ack` does not rise at that boundary.
- R3: With `alt_en`=0, `dma_chg`=0 and `dma_kind` at burst (1) or block (2), a DMA engine that holds the bus and keeps requesting keeps the grant. The other masters wait.
- R4: With `dma_kind` at cycle-steal (0), or `dma_chg`=1, a completed DMA cycle is followed by a grant to a waiting on-chip master.
- R5: With `alt_en`=1, DMA cycles and on-chip cycles alternate in burst and block runs as well.
- R6: When no rule above decides, the order is DMA engine, then transfer master, then CPU. With no request, `gnt` returns to zero.
- R7: `rel_ack` rises only at an update boundary that is not inside a DMA pair. While it is high, no external-space access is granted. It stays high while `rel_req` is high and falls on the first edge after `rel_req` drops, and the paused DMA engine resumes on that edge.
- R8: A DMA request for internal space is granted on the same edge on which `rel_ack` rises.
- R9: In a held run (R3), an on-chip external request waits while `ext_pri`=0. With `ext_pri`=1 it takes the next cycle.
- R10: While `rst_n` is low, `gnt` is zero and `rel_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_en | input | 1 | 1: DMA burst and block runs alternate with the on-chip masters |
| ext_pri | input | 1 | 1: on-chip external requests may break into a held DMA run |
| cyc_done | input | 1 | The current bus cycle ends at this edge |
| dma_req | input | 1 | DMA engine requests a cycle |
| dma_kind | input | 2 | 0 cycle-steal, 1 burst, 2 block |
| dma_chg | input | 1 | The bus is passing to another DMA channel |
| dma_rd | input | 1 | The requested DMA cycle is the read half of a pair |
| dma_ext | input | 1 | The DMA access targets external space |
| xfr_req | input | 1 | Transfer master requests a cycle |
| xfr_ext | input | 1 | The transfer master access targets external space |
| cpu_req | input | 1 | CPU requests a cycle |
| cpu_ext | input | 1 | The CPU access targets external space |
| rel_req | input | 1 | External agent asks for the external bus |
| gnt | output | 3 | One-hot grant: bit 0 DMA, bit 1 transfer master, bit 2 CPU |
| rel_ack | output | 1 | External bus is released |

## Verification
If the pair flag is wrong, it shows up on the edge right after the read completes: either a non-DMA grant or a rising `rel_ack` appears where the DMA write belongs. A stale view of the last owner shows within one cycle as a broken alternation pattern, such as two DMA grants in a row or a missing return to the DMA engine. A release state that sticks or never sets shows within a cycle of `rel_req` changing, through `rel_ack` and through whether an external-space requester gets the bus.

// File: rtl/sba_pkg.sv
// Shared definitions for the shared bus arbiter: master indices and DMA kinds.
package sba_pkg;
    localparam int NM      = 3;   // number of bus masters
    localparam int IDX_DMA = 0;   // DMA engine
    localparam int IDX_XFR = 1;   // second on-chip transfer master
    localparam int IDX_CPU = 2;   // CPU
    localparam int KW      = 2;   // width of the DMA kind code

    typedef enum logic [KW-1:0] {
        XK_STEAL = 2'd0,
        XK_BURST = 2'd1,
        XK_BLOCK = 2'd2
    } xfer_kind_e;
endpackage

// File: rtl/sba_release.sv
// External bus release handshake.
// Raises the acknowledge only at an update boundary outside a DMA pair and
// holds it until the request is withdrawn. Assumes upd marks cycle ends.
module sba_release (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic lock,
    input  logic rel_req,
    output logic rel_next,
    output logic rel_ack
);
    // Next acknowledge state: keep while requested, grant only at a legal boundary
    always_comb rel_next = rel_req && (rel_ack || (upd && !lock));

    // Acknowledge register
    always_ff @(posedge clk) begin
        if (!rst_n) rel_ack <= 1'b0;
        else        rel_ack <= rel_next;
    end

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rel_ack && rel_req |=> rel_ack);                          // R7
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_req |=> !rel_ack);                                   // R7
    AST_ACK_NOT_IN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        lock && !rel_ack |=> !rel_ack);                           // R2
endmodule

// File: rtl/sba_pick.sv
// Combinational grant selection.
// Applies, in order: pair lock, held DMA run (with an optional external break-in),
// alternation after a DMA cycle, then fixed priority DMA > transfer > CPU.
// Assumes the requests are valid at the update boundary.
module sba_pick
    import sba_pkg::*;
(
    input  logic          lock,
    input  logic          dma_owner,
    input  logic [NM-1:0] req,
    input  logic [NM-1:0] ext,
    input  logic [KW-1:0] dma_kind,
    input  logic          dma_chg,
    input  logic          alt_en,
    input  logic          ext_pri,
    input  logic          rel_next,
    output logic [NM-1:0] pick
);
    localparam logic [NM-1:0] DMA_BIT = NM'(1) << IDX_DMA;
    localparam logic [NM-1:0] ONCHIP  = ~DMA_BIT;

    logic [NM-1:0] elig;
    logic [NM-1:0] brk;
    logic          hold;
    logic          turn;

    // Lowest set bit as a one-hot vector
    function automatic logic [NM-1:0] lowbit(input logic [NM-1:0] m);
        return m & (~m + NM'(1));
    endfunction

    // Per-master eligibility: external accesses are masked during a release
    for (genvar i = 0; i < NM; i++) begin : g_elig
        assign elig[i] = req[i] && !(ext[i] && rel_next);
    end

    // Run classification of the current DMA owner
    always_comb begin
        hold = dma_owner && (xfer_kind_e'(dma_kind) != XK_STEAL) && !alt_en && !dma_chg;
        turn = dma_owner && !hold;
        brk  = ext_pri ? (elig & ext & ONCHIP) : '0;
    end

    // Grant choice by rule order
    always_comb begin
        if (lock)
            pick = DMA_BIT;
        else if (hold && elig[IDX_DMA])
            pick = (brk != '0) ? lowbit(brk) : DMA_BIT;
        else if (turn && ((elig & ONCHIP) != '0))
            pick = lowbit(elig & ONCHIP);
        else
            pick = lowbit(elig);
    end
endmodule

// File: rtl/shared_bus_arb.sv
// Shared bus arbiter for a DMA engine, a transfer master and a CPU.
// Holds the registered one-hot grant and the pair-lock state, and combines
// the selector with the release handshake. Assumes a DMA read is followed
// by its write request (dma_rd=0) without dma_req dropping.
module shared_bus_arb
    import sba_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alt_en,
    input  logic          ext_pri,
    input  logic          cyc_done,
    input  logic          dma_req,
    input  logic [KW-1:0] dma_kind,
    input  logic          dma_chg,
    input  logic          dma_rd,
    input  logic          dma_ext,
    input  logic          xfr_req,
    input  logic          xfr_ext,
    input  logic          cpu_req,
    input  logic          cpu_ext,
    input  logic          rel_req,
    output logic [NM-1:0] gnt,
    output logic          rel_ack
);
    logic [NM-1:0] grant_q;
    logic          rd_q;
    logic          ext_q;
    logic          upd;
    logic          lock;
    logic          rel_next;
    logic [NM-1:0] req;
    logic [NM-1:0] ext;
    logic [NM-1:0] pick;

    // Gather requests into master-indexed vectors
    always_comb begin
        req = '0;
        ext = '0;
        req[IDX_DMA] = dma_req;  ext[IDX_DMA] = dma_ext;
        req[IDX_XFR] = xfr_req;  ext[IDX_XFR] = xfr_ext;
        req[IDX_CPU] = cpu_req;  ext[IDX_CPU] = cpu_ext;
    end

    // Update point and pair lock
    always_comb begin
        upd  = cyc_done || (grant_q == '0);
        lock = grant_q[IDX_DMA] && rd_q;
    end

    sba_release u_rel (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .lock     (lock),
        .rel_req  (rel_req),
        .rel_next (rel_next),
        .rel_ack  (rel_ack)
    );

    sba_pick u_pick (
        .lock      (lock),
        .dma_owner (grant_q[IDX_DMA]),
        .req       (req),
        .ext       (ext),
        .dma_kind  (dma_kind),
        .dma_chg   (dma_chg),
        .alt_en    (alt_en),
        .ext_pri   (ext_pri),
        .rel_next  (rel_next),
        .pick      (pick)
    );

    // Grant register with the pair flag and space of the granted access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            rd_q    <= 1'b0;
            ext_q   <= 1'b0;
        end else if (upd) begin
            grant_q <= pick;
            rd_q    <= pick[IDX_DMA] && dma_rd;
            ext_q   <= |(pick & ext);
        end
    end

    assign gnt = grant_q;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));                                           // R1
    AST_GNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_done && (gnt != '0) |=> $stable(gnt));              // R1
    AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[IDX_DMA] && rd_q && cyc_done |=> gnt[IDX_DMA]);      // R2
    AST_NO_EXT_IN_REL: assert property (@(posedge clk) disable iff (!rst_n)
        rel_ack |-> !ext_q);                                      // R7
    AST_ALT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done && gnt[IDX_DMA] && !rd_q && alt_en && !rel_req
        && ((xfr_req && !xfr_ext) || (cpu_req && !cpu_ext))
        |=> !gnt[IDX_DMA]);                                       // R5
endmodule

// File: tb/sim_shared_bus_arb.sv
// Scoreboard bench: the driver queues the expected grant and acknowledge for
// each edge, and the monitor compares them just after that edge.
module sim_shared_bus_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alt_en = 0, ext_pri = 0, cyc_done = 1;
    logic       dma_req = 0, dma_chg = 0, dma_rd = 0, dma_ext = 0;
    logic [1:0] dma_kind = 2'd0;
    logic       xfr_req = 0, xfr_ext = 0, cpu_req = 0, cpu_ext = 0, rel_req = 0;
    logic [2:0] gnt;
    logic       rel_ack;

    typedef struct {
        logic [2:0] g;
        logic       a;
        string      tag;
    } exp_t;
    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    localparam logic [2:0] G0 = 3'b000, GD = 3'b001, GX = 3'b010, GC = 3'b100;

    always #5 clk = ~clk;

    shared_bus_arb u0 (
        .clk(clk), .rst_n(rst_n), .alt_en(alt_en), .ext_pri(ext_pri),
        .cyc_done(cyc_done), .dma_req(dma_req), .dma_kind(dma_kind),
        .dma_chg(dma_chg), .dma_rd(dma_rd), .dma_ext(dma_ext),
        .xfr_req(xfr_req), .xfr_ext(xfr_ext), .cpu_req(cpu_req),
        .cpu_ext(cpu_ext), .rel_req(rel_req), .gnt(gnt), .rel_ack(rel_ack)
    );

    // Queue an expectation for the coming edge and move to the next negedge
    task automatic expect_edge(input logic [2:0] g, input logic a, input string tag);
        exp_t e;
        e.g = g; e.a = a; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic clear_reqs();
        dma_req = 0; xfr_req = 0; cpu_req = 0; rel_req = 0;
        dma_ext = 0; xfr_ext = 0; cpu_ext = 0; dma_rd = 0; dma_chg = 0;
        alt_en = 0; ext_pri = 0; cyc_done = 1; dma_kind = 2'd0;
    endtask

    // Monitor: compare each queued item right after its edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (gnt !== e.g || rel_ack !== e.a) begin
                    n_bad++;
                    $display("FAIL %s: gnt=%b rel_ack=%b expected gnt=%b rel_ack=%b",
                             e.tag, gnt, rel_ack, e.g, e.a);
                end
            end
        end
    end

    // Driver
    initial begin
        @(negedge clk);
        expect_edge(G0, 0, "R10 reset");
        expect_edge(G0, 0, "R10 reset held");
        rst_n = 1;

        // R6 fixed priority
        xfr_req = 1; cpu_req = 1;   expect_edge(GX, 0, "R6 xfr over cpu");
        xfr_req = 0;                expect_edge(GC, 0, "R6 cpu alone");
        cpu_req = 0;                expect_edge(G0, 0, "R6 idle");

        // R1 grant stable while the cycle is running
        cpu_req = 1;                expect_edge(GC, 0, "R1 cpu granted");
        cyc_done = 0; xfr_req = 1; dma_req = 1;
                                    expect_edge(GC, 0, "R1 stable without cyc_done");
        cyc_done = 1;               expect_edge(GD, 0, "R1 R6 dma at cycle end");
        clear_reqs();               expect_edge(G0, 0, "R6 idle");

        // R4 cycle-steal alternation
        dma_req = 1; cpu_req = 1;
        expect_edge(GD, 0, "R4 steal dma");
        expect_edge(GC, 0, "R4 steal cpu");
        expect_edge(GD, 0, "R4 steal dma again");
        expect_edge(GC, 0, "R4 steal cpu again");
        clear_reqs();               expect_edge(G0, 0, "R4 idle");

        // R3 burst hold
        dma_kind = 2'd1; dma_req = 1; cpu_req = 1;
        expect_edge(GD, 0, "R3 burst first");
        expect_edge(GD, 0, "R3 burst held");
        expect_edge(GD, 0, "R3 burst held 2");
        dma_req = 0;                expect_edge(GC, 0, "R3 cpu after run");
        clear_reqs();               expect_edge(G0, 0, "R3 idle");

        // R5 alternation enabled in block mode
        alt_en = 1; dma_kind = 2'd2; dma_req = 1; cpu_req = 1;
        expect_edge(GD, 0, "R5 block dma");
        expect_edge(GC, 0, "R5 block cpu");
        expect_edge(GD, 0, "R5 block dma again");
        clear_reqs();               expect_edge(G0, 0, "R5 idle");

        // R4 channel change forces a turn
        dma_kind = 2'd1; dma_chg = 1; dma_req = 1; cpu_req = 1;
        expect_edge(GD, 0, "R4 chg dma");
        expect_edge(GC, 0, "R4 chg cpu");
        clear_reqs();               expect_edge(G0, 0, "R4 idle 2");

        // R2 and R7 pair kept whole around a release
        dma_kind = 2'd1; dma_req = 1; dma_rd = 1; dma_ext = 1;
        expect_edge(GD, 0, "R2 read granted");
        dma_rd = 0; rel_req = 1;    expect_edge(GD, 0, "R2 write follows, no ack");
        dma_rd = 1;                 expect_edge(G0, 1, "R7 ack after write");
        cpu_req = 1; cpu_ext = 1;   expect_edge(G0, 1, "R7 external held off");
        rel_req = 0; cpu_req = 0; cpu_ext = 0;
                                    expect_edge(GD, 0, "R7 ack drops, dma resumes");
        dma_rd = 0;                 expect_edge(GD, 0, "R2 write of resumed pair");
        dma_req = 0; dma_ext = 0;   expect_edge(G0, 0, "R2 idle");

        // R8 internal DMA together with a release
        clear_reqs();
        dma_req = 1; rel_req = 1;   expect_edge(GD, 1, "R8 internal dma with ack");
        clear_reqs();               expect_edge(G0, 0, "R8 idle");

        // R9 external priority break-in
        dma_kind = 2'd1; dma_req = 1; cpu_req = 1; cpu_ext = 1;
        expect_edge(GD, 0, "R9 run start");
        expect_edge(GD, 0, "R9 cpu waits without priority");
        ext_pri = 1;                expect_edge(GC, 0, "R9 cpu breaks in");
        expect_edge(GD, 0, "R9 dma back");
        clear_reqs();               expect_edge(G0, 0, "R9 idle");

        repeat (3) @(negedge clk);
        done = 1;
    end

    // Watchdog and summary
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule